// File: doc/BRIEF.md
# Pipelined Shift-and-Add Vector Rotator

This block turns a signed two-dimensional vector counter-clockwise by a requested angle. It accepts a new vector and angle on every enabled clock and returns the turned vector a fixed number of enabled clocks later. The angle is an unsigned word in which a full turn equals 2^PW. The three top angle bits pick a coarse turn by a whole number of quarter turns. That turn is only a swap and/or negation of the coordinates, and it leaves a signed residual angle of at most an eighth of a turn in magnitude. NSTAGES shift-and-add stages then steer the residual toward zero. Stage k turns the vector by ±atan(2^-k), and the sign of the residual picks the direction. A last stage narrows the widened data back to IW+1 bits with round-half-to-even.

The coarse turn has four named selections. TURN_0 passes the vector unchanged. TURN_90 maps (x, y) to (-y, x). TURN_180 maps it to (-x, -y). TURN_270 maps it to (y, -x). The selection is decided afresh for every sample, so there are no transitions between selections. A single clock enable freezes every register of the pipeline when it is low. A one-bit tag travels beside the data and comes out with the result of the sample that carried it. No gain correction is applied: the result carries the shift-and-add gain G = prod over k=1..NSTAGES of sqrt(1+2^-2k), which is about 1.1644 for 16 stages.

Top module: `cordic_rotator`

## Requirements
- R1: A sample taken on an enabled clock appears at the outputs after exactly NSTAGES+2 enabled clocks, counting the clock that captures it (18 for the defaults).
- R2: The coarse turn count is ((top three angle bits) + 1) >> 1, taken modulo 4, in quarter turns. The signed residual angle^PW minus count*2^(PW-2) then lies within ±2^(PW-3).
- R3: out_x and out_y lie within ±2 LSB of G*(x*cos(a) - y*sin(a)) and G*(y*cos(a) + x*sin(a)), where a = in_phase*2*pi/2^PW. This holds in every octant, including angles exactly on, or one unit beside, a 45-degree boundary.
- R4: Each stage k = 1..NSTAGES turns counter-clockwise and lowers the residual by round(atan(2^-k)*2^PW/(2*pi)) when the residual is non-negative. Otherwise it turns clockwise and raises the residual by the same amount. After the last stage the residual is at most that last constant plus NSTAGES in magnitude.
- R5: While ce is low no register changes: out_x, out_y and out_tag hold their values.
- R6: out_tag is high on exactly those results whose input sample had in_tag high.
- R7: Reset clears every pipeline register, so out_x, out_y and out_tag read 0 until the first sample has passed through.
- R8: The output keeps IW+1 bits and drops the WW-IW-1 low bits of the working width with round-half-to-even. The dropped value never exceeds half an output LSB.
- R9: A zero input vector gives exactly zero outputs at any angle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for the whole pipeline |
| in_x | input | IW | Signed x coordinate |
| in_y | input | IW | Signed y coordinate |
| in_phase | input | PW | Unsigned rotation angle, 2^PW per turn |
| in_tag | input | 1 | Tag bit carried with the sample |
| out_x | output | IW+1 | Signed rotated x, scaled by G |
| out_y | output | IW+1 | Signed rotated y, scaled by G |
| out_tag | output | 1 | Tag bit aligned with the result |

## Verification
Full-scale axis vectors, diagonal vectors and an off-axis vector are each turned by angles on, just above and just below every eighth-turn boundary, and by the middle of each octant. A wrong coarse-turn mapping or a wrong residual subtraction therefore shows up as a large error in one octant only. A stream from a pseudo-random generator covers arbitrary angles and magnitudes, including the most negative coordinate, where sign and overflow faults show. Zero vectors tell exact zero handling apart from tolerance effects. Idle cycles interleaved with tagged samples separate correct enable gating and tag alignment from a pipeline that drifts by one stage.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

    typedef enum logic [1:0] {
        TURN_0   = 2'd0,
        TURN_90  = 2'd1,
        TURN_180 = 2'd2,
        TURN_270 = 2'd3
    } turn_e;

    localparam real TWO_PI = 6.283185307179586;

    // arctangent by power series, valid for |t| <= 0.5
    function automatic real atan_series(input real t);
        real acc;
        real term;
        acc  = 0.0;
        term = t;
        for (int n = 0; n < 40; n++) begin
            if (n % 2 == 0)
                acc = acc + term / real'(2 * n + 1);
            else
                acc = acc - term / real'(2 * n + 1);
            term = term * t * t;
        end
        return acc;
    endfunction

    // per-stage angle in phase units (2^pw per full turn)
    function automatic int stage_angle(input int k, input int pw);
        real a;
        a = atan_series(1.0 / (2.0 ** k));
        return $rtoi(a * (2.0 ** pw) / TWO_PI + 0.5);
    endfunction

endpackage

// File: rtl/cordic_prerot.sv
module cordic_prerot
    import cordic_rot_pkg::*;
#(
    parameter int IW = 12,
    parameter int WW = 16,
    parameter int PW = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce,
    input  logic [IW-1:0]        x_i,
    input  logic [IW-1:0]        y_i,
    input  logic [PW-1:0]        ph_i,
    output logic signed [WW-1:0] x_o,
    output logic signed [WW-1:0] y_o,
    output logic signed [PW-1:0] ph_o
);
    localparam int FRAC  = WW - IW - 1;
    localparam int HALFQ = 1 << (PW - 3);

    logic signed [WW-1:0] xw, yw, x_n, y_n;
    logic [2:0]           octant, oct_inc;
    turn_e                turn;
    logic [PW-1:0]        ph_n;

    // one guard bit on top, FRAC zero bits below
    assign xw = {x_i[IW-1], x_i, {FRAC{1'b0}}};
    assign yw = {y_i[IW-1], y_i, {FRAC{1'b0}}};

    assign octant  = ph_i[PW-1 -: 3];
    assign oct_inc = octant + 3'd1;
    assign turn    = turn_e'(oct_inc[2:1]);
    assign ph_n    = ph_i - {turn, {(PW-2){1'b0}}};

    always_comb begin
        unique case (turn)
            TURN_0:   begin x_n = xw;  y_n = yw;  end
            TURN_90:  begin x_n = -yw; y_n = xw;  end
            TURN_180: begin x_n = -xw; y_n = -yw; end
            TURN_270: begin x_n = yw;  y_n = -xw; end
            default:  begin x_n = xw;  y_n = yw;  end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_o  <= '0;
            y_o  <= '0;
            ph_o <= '0;
        end else if (ce) begin
            x_o  <= x_n;
            y_o  <= y_n;
            ph_o <= ph_n;
        end
    end

    // R2: residual after the coarse turn stays within an eighth of a turn
    p_residual_range_r2: assert property (@(posedge clk) disable iff (rst)
        ce |=> (ph_o <= HALFQ) && (ph_o >= -HALFQ));

endmodule

// File: rtl/cordic_microstage.sv
module cordic_microstage #(
    parameter int WW    = 16,
    parameter int PW    = 18,
    parameter int SHIFT = 1,
    parameter int ANGLE = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce,
    input  logic signed [WW-1:0] x_i,
    input  logic signed [WW-1:0] y_i,
    input  logic signed [PW-1:0] ph_i,
    output logic signed [WW-1:0] x_o,
    output logic signed [WW-1:0] y_o,
    output logic signed [PW-1:0] ph_o
);
    localparam logic signed [PW-1:0] ANG = PW'(ANGLE);

    logic                 turn_cw;
    logic signed [WW-1:0] x_sh, y_sh;

    assign turn_cw = ph_i[PW-1];
    assign x_sh    = x_i >>> SHIFT;
    assign y_sh    = y_i >>> SHIFT;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_o  <= '0;
            y_o  <= '0;
            ph_o <= '0;
        end else if (ce) begin
            if (turn_cw) begin
                x_o  <= x_i + y_sh;
                y_o  <= y_i - x_sh;
                ph_o <= ph_i + ANG;
            end else begin
                x_o  <= x_i - y_sh;
                y_o  <= y_i + x_sh;
                ph_o <= ph_i - ANG;
            end
        end
    end

    // R4: a negative residual is raised, a non-negative one is lowered
    p_steer_up_r4: assert property (@(posedge clk) disable iff (rst)
        (ce && ph_i[PW-1]) |=> (ph_o >= $past(ph_i)));
    p_steer_down_r4: assert property (@(posedge clk) disable iff (rst)
        (ce && !ph_i[PW-1]) |=> (ph_o <= $past(ph_i)));

endmodule

// File: rtl/cordic_round_out.sv
module cordic_round_out #(
    parameter int WW = 16,
    parameter int OW = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce,
    input  logic signed [WW-1:0] x_i,
    input  logic signed [WW-1:0] y_i,
    output logic signed [OW-1:0] x_o,
    output logic signed [OW-1:0] y_o
);
    localparam int D    = WW - OW;
    localparam int STEP = 1 << D;
    localparam int HALF = STEP / 2;

    // round half to even: bias is half-minus-one plus the kept LSB
    function automatic logic signed [OW-1:0] round_even(input logic signed [WW-1:0] v);
        logic [WW-1:0]        bias;
        logic signed [WW-1:0] s;
        bias = {{OW{1'b0}}, v[D], {(D-1){~v[D]}}};
        s    = v + $signed(bias);
        return OW'(s >>> D);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            x_o <= '0;
            y_o <= '0;
        end else if (ce) begin
            x_o <= round_even(x_i);
            y_o <= round_even(y_i);
        end
    end

    // R8: dropped part never exceeds half an output LSB
    p_round_close_r8: assert property (@(posedge clk) disable iff (rst)
        ce |=> ((int'(x_o) * STEP - int'($past(x_i))) <= HALF)
            && ((int'(x_o) * STEP - int'($past(x_i))) >= -HALF)
            && ((int'(y_o) * STEP - int'($past(y_i))) <= HALF)
            && ((int'(y_o) * STEP - int'($past(y_i))) >= -HALF));

endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator
    import cordic_rot_pkg::*;
#(
    parameter int IW      = 12,
    parameter int PW      = 18,
    parameter int WW      = 16,
    parameter int NSTAGES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce,
    input  logic [IW-1:0]        in_x,
    input  logic [IW-1:0]        in_y,
    input  logic [PW-1:0]        in_phase,
    input  logic                 in_tag,
    output logic signed [IW:0]   out_x,
    output logic signed [IW:0]   out_y,
    output logic                 out_tag
);
    localparam int OW        = IW + 1;
    localparam int LAT       = NSTAGES + 2;
    localparam int RES_BOUND = stage_angle(NSTAGES, PW) + NSTAGES;

    logic signed [WW-1:0] xs  [NSTAGES+1];
    logic signed [WW-1:0] ys  [NSTAGES+1];
    logic signed [PW-1:0] phs [NSTAGES+1];
    logic [LAT-1:0]       tag_sr;

    cordic_prerot #(.IW(IW), .WW(WW), .PW(PW)) u_prerot (
        .clk  (clk),
        .rst  (rst),
        .ce   (ce),
        .x_i  (in_x),
        .y_i  (in_y),
        .ph_i (in_phase),
        .x_o  (xs[0]),
        .y_o  (ys[0]),
        .ph_o (phs[0])
    );

    for (genvar k = 0; k < NSTAGES; k++) begin : g_stage
        cordic_microstage #(
            .WW    (WW),
            .PW    (PW),
            .SHIFT (k + 1),
            .ANGLE (stage_angle(k + 1, PW))
        ) u_stage (
            .clk  (clk),
            .rst  (rst),
            .ce   (ce),
            .x_i  (xs[k]),
            .y_i  (ys[k]),
            .ph_i (phs[k]),
            .x_o  (xs[k+1]),
            .y_o  (ys[k+1]),
            .ph_o (phs[k+1])
        );
    end

    cordic_round_out #(.WW(WW), .OW(OW)) u_round (
        .clk (clk),
        .rst (rst),
        .ce  (ce),
        .x_i (xs[NSTAGES]),
        .y_i (ys[NSTAGES]),
        .x_o (out_x),
        .y_o (out_y)
    );

    // tag shift register, same depth as the data path
    always_ff @(posedge clk) begin
        if (rst)
            tag_sr <= '0;
        else if (ce)
            tag_sr <= {tag_sr[LAT-2:0], in_tag};
    end
    assign out_tag = tag_sr[LAT-1];

    // R4: residual has converged after the last stage
    p_residual_done_r4: assert property (@(posedge clk) disable iff (rst)
        (phs[NSTAGES] <= RES_BOUND) && (phs[NSTAGES] >= -RES_BOUND));

    // R5: nothing moves while the enable is low
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(out_x) && $stable(out_y) && $stable(out_tag));

    // R6: the tag can only advance on an enabled clock
    p_tag_enabled_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(out_tag) |-> $past(ce));

    // R7: outputs read zero right after reset
    p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_x == 0) && (out_y == 0) && !out_tag);

endmodule

// File: tb/sim_cordic_rotator.sv
`timescale 1ns/1ps
module sim_cordic_rotator;
    localparam int IW  = 12;
    localparam int PW  = 18;
    localparam int WW  = 16;
    localparam int NST = 16;
    localparam int LAT = NST + 2;
    localparam real TWO_PI = 6.283185307179586;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                ce  = 1'b0;
    logic [IW-1:0]       in_x = '0;
    logic [IW-1:0]       in_y = '0;
    logic [PW-1:0]       in_phase = '0;
    logic                in_tag = 1'b0;
    logic signed [IW:0]  out_x, out_y;
    logic                out_tag;

    int  checks = 0;
    int  errors = 0;
    real gain;
    real qx[$];
    real qy[$];
    bit  qt[$];
    bit  qz[$];
    int  prev_x = 0, prev_y = 0;
    bit  prev_t = 1'b0;
    int unsigned seed = 32'h1357_9bdf;

    always #4 clk = ~clk;

    cordic_rotator #(.IW(IW), .PW(PW), .WW(WW), .NSTAGES(NST)) u0 (
        .clk(clk), .rst(rst), .ce(ce),
        .in_x(in_x), .in_y(in_y), .in_phase(in_phase), .in_tag(in_tag),
        .out_x(out_x), .out_y(out_y), .out_tag(out_tag)
    );

    task automatic chk(input bit ok, input string req, input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0f expected %0f", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, observe at the next negedge
    task automatic step(input int x, input int y, input int ph, input bit tag, input bit en);
        real a, ex, ey;
        in_x     = x[IW-1:0];
        in_y     = y[IW-1:0];
        in_phase = ph[PW-1:0];
        in_tag   = tag;
        ce       = en;
        @(posedge clk);
        if (en) begin
            a  = real'(ph) * TWO_PI / (2.0 ** PW);
            ex = gain * (real'(x) * $cos(a) - real'(y) * $sin(a));
            ey = gain * (real'(y) * $cos(a) + real'(x) * $sin(a));
            qx.push_back(ex);
            qy.push_back(ey);
            qt.push_back(tag);
            qz.push_back(x == 0 && y == 0);
        end
        @(negedge clk);
        if (!en) begin
            // R5: idle clock leaves outputs where they were
            chk(int'(out_x) == prev_x, "R5 x hold", real'(out_x), real'(prev_x));
            chk(int'(out_y) == prev_y, "R5 y hold", real'(out_y), real'(prev_y));
            chk(out_tag == prev_t, "R5 tag hold", real'(out_tag), real'(prev_t));
        end else if (qx.size() == LAT) begin
            ex = qx.pop_front();
            ey = qy.pop_front();
            chk((real'(out_x) - ex <= 2.0) && (ex - real'(out_x) <= 2.0),
                "R3,R4,R8 x within 2 LSB", real'(out_x), ex);
            chk((real'(out_y) - ey <= 2.0) && (ey - real'(out_y) <= 2.0),
                "R3,R4,R8 y within 2 LSB", real'(out_y), ey);
            chk(out_tag == qt.pop_front(), "R1,R6 tag alignment",
                real'(out_tag), real'(out_tag ^ 1'b1) * 0.0);
            if (qz.pop_front())
                chk(out_x == 0 && out_y == 0, "R9 zero vector", real'(out_x) + real'(out_y), 0.0);
        end else begin
            // R7: reset values until the first result arrives
            chk(out_x == 0 && out_y == 0 && !out_tag, "R7 cleared output",
                real'(out_x) + real'(out_y) + real'(out_tag), 0.0);
        end
        prev_x = int'(out_x);
        prev_y = int'(out_y);
        prev_t = out_tag;
    endtask

    function automatic int rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'(seed >> 8);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int vx[4];
        int vy[4];
        int offs[4];
        int n;
        gain = 1.0;
        for (int k = 1; k <= NST; k++)
            gain = gain * $sqrt(1.0 + 2.0 ** (-2.0 * k));
        vx = '{2047, 0, -1448, 1000};
        vy = '{0, -2048, 1448, -300};
        offs = '{0, 1, -1, 16384};

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_x == 0 && out_y == 0 && !out_tag, "R7 after reset",
            real'(out_x) + real'(out_y) + real'(out_tag), 0.0);

        // octant boundaries, neighbours and mid-octant angles (R2, R3)
        n = 0;
        for (int o = 0; o < 8; o++) begin
            for (int j = 0; j < 4; j++) begin
                for (int v = 0; v < 4; v++) begin
                    step(vx[v], vy[v], (o * 32768 + offs[j]) & ((1 << PW) - 1),
                         (n % 5) == 2, 1'b1);
                    n++;
                    if (n % 7 == 0) step(0, 0, 0, 1'b1, 1'b0);
                end
            end
        end

        // zero vectors at several angles (R9)
        for (int j = 0; j < 6; j++)
            step(0, 0, j * 45001, j[0], 1'b1);

        // pseudo-random stream with idle gaps and tags (R1, R5, R6)
        for (int j = 0; j < 300; j++) begin
            int r1, r2, r3;
            r1 = rnd();
            r2 = rnd();
            r3 = rnd();
            step(int'($signed(r1[11:0])), int'($signed(r2[11:0])),
                 r3 & ((1 << PW) - 1), r1[20], 1'b1);
            if (r2[19:18] == 2'b00) step(r3 & 2047, r1 & 2047, r2 & 1023, 1'b1, 1'b0);
        end

        // drain the pipeline
        for (int j = 0; j < LAT; j++)
            step(0, 0, 0, 1'b0, 1'b1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule